// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block sits on the local write path in front of a serial link. A local write whose address lands inside a fixed outbound window is steered to a link address. The window is cut into equal regions. Each region holds its own programmed link base, an upper 32-bit extension and an enable. The region-index bits of the local address and everything above them are replaced by the region's link base. The offset inside the region is carried across unchanged, so a write to window offset 0x54 reaches offset 0x54 above the programmed link base. Because of this, software can aim one region at a remote register block, such as a far-side interrupt doorbell, for a single write and then aim it back at a data buffer.

A global translation enable gates the whole unit. A window write is forwarded only when the global enable and the region's own enable are both set. Otherwise the write is dropped and a one-cycle error pulse is raised. Addresses outside the window go through untouched, with the hit flag low. Results come out registered, one cycle after the request. Region settings may be rewritten between any two writes.

Top module: `obxlt_unit`

## Requirements
- R1: After reset, `out_valid`, `out_hit` and `out_err` are 0 and every region is disabled. A window write with the global enable set is then dropped with `out_err`.
- R2: An address is in the window when bits [31:28] equal 0x6 (window 0x6000_0000 to 0x6FFF_FFFF, 256 MB). The region index is address bits [27:23], which gives 32 regions of 8 MB.
- R3: A translated write gives `out_addr = {hi, link_top, req_addr[22:0]}`. Here `hi` is the region's 32-bit upper register and `link_top` is its 9-bit link base (link address bits [31:23]). A region with `hi` = 0 yields an address whose upper 32 bits are zero.
- R4: A window write while `glb_xlt_en` is 0 is dropped: `out_valid` = 0 and `out_err` = 1.
- R5: A window write to a region whose enable is 0 is dropped with `out_err` = 1, even when `glb_xlt_en` is 1.
- R6: A write outside the window is forwarded with `out_hit` = 0 and `out_addr` equal to the local address zero-extended to 64 bits, whatever the enables are.
- R7: Every forwarded write appears on the outputs exactly one clock after it is presented, with `out_data` equal to the request data.
- R8: A configuration write in the same cycle as a request does not affect that request. The request uses the setting in force before that edge, and the following request uses the new setting.
- R9: In a cycle after no request was presented, `out_valid` and `out_err` are 0.
- R10: `out_err` is never high together with `out_valid` or `out_hit`, and each dropped write raises it for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_xlt_en | input | 1 | Global outbound translation enable |
| cfg_we | input | 1 | Write strobe for one region's settings |
| cfg_idx | input | 5 | Region written by `cfg_we` |
| cfg_link_top | input | 9 | Region link base, link address bits [31:23] |
| cfg_link_hi | input | 32 | Region upper link address bits [63:32] |
| cfg_rgn_en | input | 1 | Region enable value written |
| req_valid | input | 1 | Local write request |
| req_addr | input | 32 | Local write address |
| req_data | input | 32 | Local write data |
| out_valid | output | 1 | Forwarded write valid |
| out_hit | output | 1 | Forwarded write was translated |
| out_err | output | 1 | One-cycle pulse for a dropped window write |
| out_addr | output | 64 | Link address |
| out_data | output | 32 | Write data, unchanged |

## Verification
The hardest case to reach is a region being retargeted in the very cycle a write to that region is accepted. That case is what separates "the setting in force at acceptance" from a late or early update. The bench raises the configuration strobe and the request on the same falling edge. It expects the old link base on that write and the new base on the write that follows. The top and bottom offsets of the last and a middle region are also driven, so that an off-by-one in the index or offset split shows up in the link address.

// File: rtl/obxlt_pkg.sv
package obxlt_pkg;
    localparam int LADDR_W = 32;
    localparam int DATA_W  = 32;
    localparam int LINK_W  = 64;

    typedef struct packed {
        logic                valid;
        logic                hit;
        logic                err;
        logic [LINK_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } xlt_out_t;

    typedef enum logic [1:0] {
        XLT_PASS  = 2'd0,
        XLT_MAP   = 2'd1,
        XLT_DROP  = 2'd2,
        XLT_IDLE  = 2'd3
    } xlt_act_e;

    function automatic xlt_act_e pick_action(logic valid, logic in_win,
                                             logic glb_en, logic rgn_en);
        if (!valid)                  return XLT_IDLE;
        else if (!in_win)            return XLT_PASS;
        else if (glb_en && rgn_en)   return XLT_MAP;
        else                         return XLT_DROP;
    endfunction
endpackage

// File: rtl/obxlt_decode.sv
module obxlt_decode #(
    parameter logic [31:0] WIN_BASE = 32'h6000_0000,
    parameter int          WIN_LOG2 = 28,
    parameter int          RGN_LOG2 = 5,
    localparam int         OFF_W    = WIN_LOG2 - RGN_LOG2
) (
    input  logic [obxlt_pkg::LADDR_W-1:0] addr,
    output logic                          in_win,
    output logic [RGN_LOG2-1:0]           idx,
    output logic [OFF_W-1:0]              offset
);
    localparam int AW = obxlt_pkg::LADDR_W;

    always_comb begin
        in_win = (addr[AW-1:WIN_LOG2] == WIN_BASE[AW-1:WIN_LOG2]);
        idx    = addr[WIN_LOG2-1:OFF_W];
        offset = addr[OFF_W-1:0];
    end
endmodule

// File: rtl/obxlt_region_file.sv
module obxlt_region_file #(
    parameter int  RGN_LOG2 = 5,
    parameter int  TOP_W    = 9,
    localparam int RGNS     = 1 << RGN_LOG2,
    localparam int HI_W     = obxlt_pkg::LINK_W - obxlt_pkg::LADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [RGN_LOG2-1:0] wr_idx,
    input  logic [TOP_W-1:0]    wr_top,
    input  logic [HI_W-1:0]     wr_hi,
    input  logic                wr_en,
    input  logic [RGN_LOG2-1:0] rd_idx,
    output logic [TOP_W-1:0]    rd_top,
    output logic [HI_W-1:0]     rd_hi,
    output logic                rd_en
);
    logic [TOP_W-1:0] top_q [RGNS];
    logic [HI_W-1:0]  hi_q  [RGNS];
    logic [RGNS-1:0]  en_q;

    for (genvar g = 0; g < RGNS; g++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (rst) begin
                top_q[g] <= '0;
                hi_q[g]  <= '0;
                en_q[g]  <= 1'b0;
            end else if (we && wr_idx == RGN_LOG2'(g)) begin
                top_q[g] <= wr_top;
                hi_q[g]  <= wr_hi;
                en_q[g]  <= wr_en;
            end
        end
    end

    always_comb begin
        rd_top = top_q[rd_idx];
        rd_hi  = hi_q[rd_idx];
        rd_en  = en_q[rd_idx];
    end
endmodule

// File: rtl/obxlt_unit.sv
module obxlt_unit #(
    parameter logic [31:0] WIN_BASE = 32'h6000_0000,
    parameter int          WIN_LOG2 = 28,
    parameter int          RGN_LOG2 = 5,
    localparam int         OFF_W    = WIN_LOG2 - RGN_LOG2,
    localparam int         TOP_W    = obxlt_pkg::LADDR_W - OFF_W,
    localparam int         HI_W     = obxlt_pkg::LINK_W - obxlt_pkg::LADDR_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          glb_xlt_en,
    input  logic                          cfg_we,
    input  logic [RGN_LOG2-1:0]           cfg_idx,
    input  logic [TOP_W-1:0]              cfg_link_top,
    input  logic [HI_W-1:0]               cfg_link_hi,
    input  logic                          cfg_rgn_en,
    input  logic                          req_valid,
    input  logic [obxlt_pkg::LADDR_W-1:0] req_addr,
    input  logic [obxlt_pkg::DATA_W-1:0]  req_data,
    output logic                          out_valid,
    output logic                          out_hit,
    output logic                          out_err,
    output logic [obxlt_pkg::LINK_W-1:0]  out_addr,
    output logic [obxlt_pkg::DATA_W-1:0]  out_data
);
    import obxlt_pkg::*;

    logic                in_win;
    logic [RGN_LOG2-1:0] idx;
    logic [OFF_W-1:0]    offset;
    logic [TOP_W-1:0]    rgn_top;
    logic [HI_W-1:0]     rgn_hi;
    logic                rgn_en;
    xlt_act_e            act;
    xlt_out_t            nxt, cur;

    obxlt_decode #(.WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .RGN_LOG2(RGN_LOG2)) dec_i (
        .addr   (req_addr),
        .in_win (in_win),
        .idx    (idx),
        .offset (offset)
    );

    obxlt_region_file #(.RGN_LOG2(RGN_LOG2), .TOP_W(TOP_W)) rf_i (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wr_idx (cfg_idx),
        .wr_top (cfg_link_top),
        .wr_hi  (cfg_link_hi),
        .wr_en  (cfg_rgn_en),
        .rd_idx (idx),
        .rd_top (rgn_top),
        .rd_hi  (rgn_hi),
        .rd_en  (rgn_en)
    );

    always_comb begin
        act      = pick_action(req_valid, in_win, glb_xlt_en, rgn_en);
        nxt      = '0;
        nxt.data = req_data;
        unique case (act)
            XLT_PASS: begin
                nxt.valid = 1'b1;
                nxt.addr  = {{HI_W{1'b0}}, req_addr};
            end
            XLT_MAP: begin
                nxt.valid = 1'b1;
                nxt.hit   = 1'b1;
                nxt.addr  = {rgn_hi, rgn_top, offset};
            end
            XLT_DROP: nxt.err = 1'b1;
            default:  nxt.data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign out_valid = cur.valid;
    assign out_hit   = cur.hit;
    assign out_err   = cur.err;
    assign out_addr  = cur.addr;
    assign out_data  = cur.data;
endmodule

// File: rtl/obxlt_unit_chk.sv
module obxlt_unit_chk #(
    parameter logic [31:0] WIN_BASE = 32'h6000_0000,
    parameter int          WIN_LOG2 = 28,
    parameter int          OFF_W    = 23
) (
    input logic        clk,
    input logic        rst,
    input logic        glb_xlt_en,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [31:0] req_data,
    input logic        out_valid,
    input logic        out_hit,
    input logic        out_err,
    input logic [63:0] out_addr,
    input logic [31:0] out_data
);
    logic req_in_win;
    assign req_in_win = (req_addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2]);

    // R3: offset inside region survives translation
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!(out_valid && out_hit) || out_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])));

    // R4: global enable off drops window writes
    a_r4_glb_off_drop: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_in_win && !glb_xlt_en) |=> (out_err && !out_valid));

    // R6: outside window passes through untranslated
    a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_in_win) |=> (out_valid && !out_hit && out_addr == {32'h0, $past(req_addr)}));

    // R7: data unchanged, one cycle later
    a_r7_data_kept: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!out_valid || out_data == $past(req_data)));

    // R9: no request, no output
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && !out_err));

    // R10: error exclusive of valid and hit
    a_r10_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (!out_valid && !out_hit));
endmodule

bind obxlt_unit obxlt_unit_chk #(.WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .OFF_W(OFF_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .glb_xlt_en (glb_xlt_en),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .out_valid  (out_valid),
    .out_hit    (out_hit),
    .out_err    (out_err),
    .out_addr   (out_addr),
    .out_data   (out_data)
);

// File: tb/obxlt_unit_tb_top.sv
module obxlt_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        glb_xlt_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [8:0]  cfg_link_top = '0;
    logic [31:0] cfg_link_hi = '0;
    logic        cfg_rgn_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        out_valid, out_hit, out_err;
    logic [63:0] out_addr;
    logic [31:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    obxlt_unit dut_i (
        .clk(clk), .rst(rst), .glb_xlt_en(glb_xlt_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_link_top(cfg_link_top),
        .cfg_link_hi(cfg_link_hi), .cfg_rgn_en(cfg_rgn_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .out_valid(out_valid), .out_hit(out_hit), .out_err(out_err),
        .out_addr(out_addr), .out_data(out_data)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(int idx, logic [8:0] top, logic [31:0] hi, logic en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_link_top = top;
        cfg_link_hi = hi; cfg_rgn_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // presents one write; outputs sampled at the following falling edge
    task automatic send(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_map(string req, logic [63:0] a, logic [31:0] d);
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " hit"}, 64'(out_hit), 64'd1);
        chk({req, " err"}, 64'(out_err), 64'd0);
        chk({req, " addr"}, out_addr, a);
        chk({req, " data"}, 64'(out_data), 64'(d));
    endtask

    task automatic expect_drop(string req);
        chk({req, " valid"}, 64'(out_valid), 64'd0);
        chk({req, " err"}, 64'(out_err), 64'd1);
    endtask

    task automatic t_reset;
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset hit", 64'(out_hit), 64'd0);
        chk("R1 reset err", 64'(out_err), 64'd0);
        glb_xlt_en = 1'b1;
        send(32'h6000_0054, 32'h1);
        expect_drop("R1 regions off after reset");
    endtask

    task automatic t_basic_map;
        cfg(0, 9'h0E0, 32'h0, 1'b1);
        send(32'h6000_0054, 32'h0);
        expect_map("R3 region0 0x6000_0054", 64'h0000_0000_7000_0054, 32'h0);
    endtask

    task automatic t_last_region;
        cfg(31, 9'h141, 32'h0000_0001, 1'b1);
        send(32'h6F80_1234, 32'hCAFE_F00D);
        expect_map("R2 R3 region31 hi", 64'h0000_0001_A080_1234, 32'hCAFE_F00D);
    endtask

    task automatic t_region_enable;
        send(32'h62FF_FFFF, 32'h5);
        expect_drop("R5 region5 disabled");
        cfg(5, 9'h020, 32'h0, 1'b1);
        send(32'h62FF_FFFF, 32'h6);
        expect_map("R2 region5 top offset", 64'h0000_0000_107F_FFFF, 32'h6);
        send(32'h6280_0000, 32'h7);
        expect_map("R2 region5 bottom offset", 64'h0000_0000_1000_0000, 32'h7);
    endtask

    task automatic t_global_off;
        glb_xlt_en = 1'b0;
        send(32'h6000_0054, 32'h9);
        expect_drop("R4 global off");
        @(negedge clk);
        chk("R10 err one cycle", 64'(out_err), 64'd0);
        chk("R9 idle valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_outside;
        send(32'h5FFF_FFFC, 32'hAAAA_5555);
        chk("R6 below valid", 64'(out_valid), 64'd1);
        chk("R6 below hit", 64'(out_hit), 64'd0);
        chk("R6 below addr", out_addr, 64'h0000_0000_5FFF_FFFC);
        chk("R7 below data", 64'(out_data), 64'hAAAA_5555);
        glb_xlt_en = 1'b1;
        send(32'h7000_0000, 32'h1234);
        chk("R6 above hit", 64'(out_hit), 64'd0);
        chk("R6 above addr", out_addr, 64'h0000_0000_7000_0000);
    endtask

    task automatic t_retarget_same_cycle;
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'd0; cfg_link_top = 9'h120;
        cfg_link_hi = 32'h0; cfg_rgn_en = 1'b1;
        req_valid = 1'b1; req_addr = 32'h6000_0010; req_data = 32'hD00B;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        expect_map("R8 old setting", 64'h0000_0000_7000_0010, 32'hD00B);
        send(32'h6000_0010, 32'hD00C);
        expect_map("R8 new setting", 64'h0000_0000_9000_0010, 32'hD00C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic_map();
        t_last_region();
        t_region_enable();
        t_global_off();
        t_outside();
        t_retarget_same_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule